// File: doc/BRIEF.md
# Speech Data FIFO Handshake Controller

This block is a byte-wide receive buffer placed between a host processor port and a speech-synthesis data consumer. The host writes command or data bytes with a parallel write strobe. The block can also build bytes from a serial ROM stream, one bit per strobe. It keeps up to sixteen bytes in arrival order and hands the oldest one to the consumer whenever the consumer asks for it.

Flow control uses two outputs. The ready output falls while all sixteen entries are occupied. The interrupt output rises when the buffer has drained to half or below, or when the consumer reports that a phrase has finished. Each condition is held as its own flag in an 8-bit status word. The host can see that word at any time, and a status read strobe clears the latched flags. The interrupt is a level that stays high until that read, so the host side can detect its rising edge.

Two state machines run the block. The fill tracker has the states FILL_EMPTY, FILL_LOW (1 to 8 entries), FILL_HIGH (9 to 15) and FILL_FULL. Its transitions are:
- FILL_EMPTY to FILL_LOW on an accepted push.
- FILL_LOW to FILL_EMPTY on the last pop.
- FILL_LOW to FILL_HIGH when occupancy passes the half mark.
- FILL_HIGH to FILL_LOW when occupancy drops back to the half mark.
- FILL_HIGH to FILL_FULL on the sixteenth entry.
- FILL_FULL to FILL_HIGH on a pop.

The interrupt machine has the states IRQ_QUIET and IRQ_ALERT. It moves from IRQ_QUIET to IRQ_ALERT on a low-water or phrase-done event. It moves from IRQ_ALERT back to IRQ_QUIET on a status read, unless a new event arrives in the same cycle.

Top module: `spch_fifo_ctrl`

## Requirements
- R1: Bytes leave through pop_data in the same order they were accepted, with up to 16 entries held at once.
- R2: ready_o is low, and status bit 2 (full) is 1, exactly while 16 entries are held. A pop from full raises ready_o again.
- R3: Any accepted push or pop that leaves 8 or fewer entries sets status bit 0 (low-water) and drives irq_o high from the next cycle.
- R4: An accepted push that leaves more than 8 entries sets no flag, and irq_o stays low.
- R5: A push attempted while full is dropped, leaves the stored bytes unchanged and sets status bit 3 (overflow). Overflow does not raise irq_o.
- R6: A pop request on an empty buffer gives pop_valid low and pop_data zero in the next cycle, and sets status bit 4 (underrun).
- R7: A phrase_end pulse sets status bit 1 (phrase done) and drives irq_o high from the next cycle.
- R8: A stat_rd pulse clears status bits 0, 1, 3 and 4 and drops irq_o at the next edge. A flag set in the same cycle as the read wins. After reset every status bit is 0, irq_o is 0 and ready_o is 1.
- R9: With ser_mode high, each ser_stb captures ser_bit, least significant bit first. The byte is pushed on the edge of the eighth strobe.
- R10: With ser_mode high, host_wr is ignored: no push and no overflow. With ser_mode low, ser_stb is ignored.
- R11: A pop request on a non-empty buffer presents the byte with pop_valid high in the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host byte write strobe |
| host_wdata | input | 8 | Host byte |
| stat_rd | input | 1 | Status read strobe, clears latched flags |
| status_o | output | 8 | Status: 0 low-water, 1 phrase done, 2 full, 3 overflow, 4 underrun, 7:5 zero |
| ser_mode | input | 1 | 1 selects the serial input path |
| ser_stb | input | 1 | Serial bit strobe |
| ser_bit | input | 1 | Serial data bit |
| pop_req | input | 1 | Consumer pop request |
| pop_data | output | 8 | Popped byte (zero after an empty pop) |
| pop_valid | output | 1 | pop_data holds a real byte |
| phrase_end | input | 1 | Consumer reports end of phrase |
| ready_o | output | 1 | Host may write |
| irq_o | output | 1 | Interrupt level, high until status read |

## Verification
The buffer is first filled one byte at a time from empty to full and then past full. This separates the acknowledged writes at or below half from the silent writes above half, and shows where ready falls and where the dropped write lands. It is then drained through the half mark to empty and beyond, which exercises the low-water crossing, a read that collides with a new event, and underrun. Serial bytes with asymmetric bit patterns (A5, 3C) show the bit order. A host write during serial mode, and serial strobes during parallel mode, must leave no trace in the popped stream or the flags.

// File: rtl/spch_pkg.sv
package spch_pkg;
    typedef enum logic [1:0] {
        FILL_EMPTY,
        FILL_LOW,
        FILL_HIGH,
        FILL_FULL
    } fill_t;

    typedef enum logic {
        IRQ_QUIET,
        IRQ_ALERT
    } irq_t;

    localparam int STAT_W  = 8;
    localparam int ST_LOW  = 0;
    localparam int ST_DONE = 1;
    localparam int ST_FULL = 2;
    localparam int ST_OVF  = 3;
    localparam int ST_UNF  = 4;
endpackage

// File: rtl/spch_ser_asm.sv
module spch_ser_asm #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          bit_stb,
    input  logic          bit_in,
    output logic          byte_stb,
    output logic [DW-1:0] byte_out
);
    localparam int BC_W = $clog2(DW);

    logic [BC_W-1:0] bcnt;
    logic [DW-1:0]   shreg;
    logic            last;

    assign last = (bcnt == BC_W'(DW - 1));

    // bit counter and shift storage, LSB first
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bcnt  <= '0;
            shreg <= '0;
        end else if (!en) begin
            bcnt <= '0;
        end else if (bit_stb) begin
            shreg[bcnt] <= bit_in;
            bcnt        <= last ? '0 : bcnt + 1'b1;
        end
    end

    // completed byte includes the bit arriving on the final strobe
    always_comb begin
        byte_out       = shreg;
        byte_out[bcnt] = bit_in;
    end

    assign byte_stb = en && bit_stb && last;
endmodule

// File: rtl/spch_fifo_core.sv
module spch_fifo_core
    import spch_pkg::*;
#(
    parameter int DW       = 8,
    parameter int DEPTH    = 16,
    parameter int LOW_MARK = DEPTH / 2,
    localparam int AW      = $clog2(DEPTH),
    localparam int CW      = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] pop_data,
    output logic          pop_valid,
    output logic          acc_push,
    output logic          acc_pop,
    output logic          low_evt,
    output logic          full,
    output logic [CW-1:0] occ
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] occ_nxt;
    fill_t         fill_q, fill_nxt;

    assign acc_push = push && (fill_q != FILL_FULL);
    assign acc_pop  = pop && (fill_q != FILL_EMPTY);
    assign occ_nxt  = occ + CW'(acc_push) - CW'(acc_pop);
    assign low_evt  = (acc_push || acc_pop) && (occ_nxt <= CW'(LOW_MARK));

    // fill state transitions
    always_comb begin
        fill_nxt = fill_q;
        unique case (fill_q)
            FILL_EMPTY: if (acc_push) fill_nxt = FILL_LOW;
            FILL_LOW: begin
                if (occ_nxt == '0)                fill_nxt = FILL_EMPTY;
                else if (occ_nxt > CW'(LOW_MARK)) fill_nxt = FILL_HIGH;
            end
            FILL_HIGH: begin
                if (occ_nxt == CW'(DEPTH))         fill_nxt = FILL_FULL;
                else if (occ_nxt <= CW'(LOW_MARK)) fill_nxt = FILL_LOW;
            end
            FILL_FULL: if (occ_nxt < CW'(DEPTH)) fill_nxt = FILL_HIGH;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q <= FILL_EMPTY;
            occ    <= '0;
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            fill_q <= fill_nxt;
            occ    <= occ_nxt;
            if (acc_push) wr_ptr <= wr_ptr + 1'b1;
            if (acc_pop)  rd_ptr <= rd_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (acc_push) mem[wr_ptr] <= push_data;
    end

    // output process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pop_data  <= '0;
            pop_valid <= 1'b0;
        end else begin
            pop_valid <= acc_pop;
            if (acc_pop)  pop_data <= mem[rd_ptr];
            else if (pop) pop_data <= '0;
        end
    end

    assign full = (fill_q == FILL_FULL);
endmodule

// File: rtl/spch_irq_ctrl.sv
module spch_irq_ctrl
    import spch_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              low_evt,
    input  logic              done_evt,
    input  logic              ovf_evt,
    input  logic              unf_evt,
    input  logic              full,
    input  logic              stat_rd,
    output logic [STAT_W-1:0] status,
    output logic              irq
);
    logic f_low, f_done, f_ovf, f_unf;
    irq_t st_q, st_nxt;

    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            IRQ_QUIET: if (low_evt || done_evt) st_nxt = IRQ_ALERT;
            IRQ_ALERT: if (stat_rd && !low_evt && !done_evt) st_nxt = IRQ_QUIET;
        endcase
    end

    // state and flag registers; a same-cycle event beats the read clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= IRQ_QUIET;
            f_low  <= 1'b0;
            f_done <= 1'b0;
            f_ovf  <= 1'b0;
            f_unf  <= 1'b0;
        end else begin
            st_q   <= st_nxt;
            f_low  <= (f_low  && !stat_rd) || low_evt;
            f_done <= (f_done && !stat_rd) || done_evt;
            f_ovf  <= (f_ovf  && !stat_rd) || ovf_evt;
            f_unf  <= (f_unf  && !stat_rd) || unf_evt;
        end
    end

    // outputs
    always_comb begin
        status          = '0;
        status[ST_LOW]  = f_low;
        status[ST_DONE] = f_done;
        status[ST_FULL] = full;
        status[ST_OVF]  = f_ovf;
        status[ST_UNF]  = f_unf;
        irq             = (st_q == IRQ_ALERT);
    end
endmodule

// File: rtl/spch_fifo_ctrl.sv
module spch_fifo_ctrl
    import spch_pkg::*;
#(
    parameter int DW       = 8,
    parameter int DEPTH    = 16,
    parameter int LOW_MARK = DEPTH / 2,
    localparam int CW      = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [DW-1:0]     host_wdata,
    input  logic              stat_rd,
    output logic [STAT_W-1:0] status_o,
    input  logic              ser_mode,
    input  logic              ser_stb,
    input  logic              ser_bit,
    input  logic              pop_req,
    output logic [DW-1:0]     pop_data,
    output logic              pop_valid,
    input  logic              phrase_end,
    output logic              ready_o,
    output logic              irq_o
);
    logic          ser_byte_stb;
    logic [DW-1:0] ser_byte;
    logic          push;
    logic [DW-1:0] push_data;
    logic          acc_push, acc_pop, low_evt, full;
    logic [CW-1:0] occ;

    spch_ser_asm #(.DW(DW)) u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (ser_mode),
        .bit_stb  (ser_stb),
        .bit_in   (ser_bit),
        .byte_stb (ser_byte_stb),
        .byte_out (ser_byte)
    );

    // source select: the unused path is ignored
    assign push      = ser_mode ? ser_byte_stb : host_wr;
    assign push_data = ser_mode ? ser_byte : host_wdata;

    spch_fifo_core #(.DW(DW), .DEPTH(DEPTH), .LOW_MARK(LOW_MARK)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (push_data),
        .pop       (pop_req),
        .pop_data  (pop_data),
        .pop_valid (pop_valid),
        .acc_push  (acc_push),
        .acc_pop   (acc_pop),
        .low_evt   (low_evt),
        .full      (full),
        .occ       (occ)
    );

    spch_irq_ctrl u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .low_evt  (low_evt),
        .done_evt (phrase_end),
        .ovf_evt  (push && !acc_push),
        .unf_evt  (pop_req && !acc_pop),
        .full     (full),
        .stat_rd  (stat_rd),
        .status   (status_o),
        .irq      (irq_o)
    );

    assign ready_o = !full;
endmodule

// File: rtl/spch_fifo_chk.sv
module spch_fifo_chk
    import spch_pkg::*;
#(
    parameter int DW       = 8,
    parameter int DEPTH    = 16,
    parameter int LOW_MARK = DEPTH / 2,
    localparam int CW      = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          host_wr,
    input logic          ser_mode,
    input logic          ser_stb,
    input logic          stat_rd,
    input logic          pop_req,
    input logic          phrase_end,
    input logic          ready_o,
    input logic          irq_o,
    input logic [4:0]    st,
    input logic          pop_valid,
    input logic [DW-1:0] pop_data,
    input logic [CW-1:0] occ
);
    AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CW'(DEPTH)); // R1
    AST_FULL_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == CW'(DEPTH)) |-> (!ready_o && st[ST_FULL])); // R2
    AST_READY_BELOW_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (occ < CW'(DEPTH)) |-> ready_o); // R2
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ($past(phrase_end) || occ <= CW'(LOW_MARK))); // R3
    AST_QUIET_ABOVE_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !ser_mode && !irq_o && !pop_req && !phrase_end
         && occ >= CW'(LOW_MARK)) |=> !irq_o); // R4
    AST_OVERFLOW_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !ser_mode && !ready_o) |=> st[ST_OVF]); // R5
    AST_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && occ == '0) |=> (!pop_valid && pop_data == '0 && st[ST_UNF])); // R6
    AST_PHRASE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        phrase_end |=> (irq_o && st[ST_DONE])); // R7
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !phrase_end && !host_wr && !ser_stb && !pop_req)
        |=> (!irq_o && !st[ST_LOW] && !st[ST_DONE] && !st[ST_OVF] && !st[ST_UNF])); // R8
    AST_POP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        pop_valid |-> $past(pop_req)); // R11
endmodule

bind spch_fifo_ctrl spch_fifo_chk #(.DW(DW), .DEPTH(DEPTH), .LOW_MARK(LOW_MARK)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .ser_mode   (ser_mode),
    .ser_stb    (ser_stb),
    .stat_rd    (stat_rd),
    .pop_req    (pop_req),
    .phrase_end (phrase_end),
    .ready_o    (ready_o),
    .irq_o      (irq_o),
    .st         (status_o[4:0]),
    .pop_valid  (pop_valid),
    .pop_data   (pop_data),
    .occ        (occ)
);

// File: tb/tb_spch_fifo_ctrl.sv
`timescale 1ns/1ps
module tb_spch_fifo_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0, stat_rd = 1'b0, ser_mode = 1'b0;
    logic       ser_stb = 1'b0, ser_bit = 1'b0, pop_req = 1'b0, phrase_end = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] status_o, pop_data;
    logic       pop_valid, ready_o, irq_o;

    int errs = 0, checks = 0;
    bit finished = 0;
    logic [7:0] q[$];   // model contents
    logic [7:0] sb[$];  // expected pop results
    logic m_low = 0, m_done = 0, m_ovf = 0, m_unf = 0;
    int   m_sc = 0;
    logic [7:0] m_sacc = '0;

    spch_fifo_ctrl dut (.*);

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_outs(input string tag);
        chk({tag, " irq"}, irq_o, int'(m_low | m_done));
        chk({tag, " ready"}, ready_o, int'(q.size() < 16));
        chk({tag, " status"}, status_o,
            int'({3'b000, m_unf, m_ovf, q.size() == 16, m_done, m_low}));
    endtask

    // driver: one cycle of stimulus plus the reference model update
    task automatic step(input logic wr, input logic [7:0] wd, input logic pp,
                        input logic rd, input logic pe, input logic sstb, input logic sbit);
        logic push_req, acc_push, acc_pop;
        logic [7:0] pd;
        host_wr = wr; host_wdata = wd; pop_req = pp; stat_rd = rd;
        phrase_end = pe; ser_stb = sstb; ser_bit = sbit;
        @(posedge clk);
        push_req = wr && !ser_mode;
        pd = wd;
        if (ser_mode && sstb) begin
            m_sacc[m_sc] = sbit;
            if (m_sc == 7) begin
                push_req = 1'b1; pd = m_sacc; m_sc = 0;
            end else m_sc++;
        end
        if (!ser_mode) m_sc = 0;
        acc_push = push_req && q.size() < 16;
        acc_pop  = pp && q.size() > 0;
        if (rd) begin m_low = 0; m_done = 0; m_ovf = 0; m_unf = 0; end
        if (acc_pop) sb.push_back(q.pop_front());
        if (pp && !acc_pop) m_unf = 1;
        if (push_req && !acc_push) m_ovf = 1;
        if (acc_push) q.push_back(pd);
        if ((acc_push || acc_pop) && q.size() <= 8) m_low = 1;
        if (pe) m_done = 1;
        @(negedge clk);
        host_wr = 0; pop_req = 0; stat_rd = 0; phrase_end = 0; ser_stb = 0;
    endtask

    task automatic wr_byte(input logic [7:0] d); step(1, d, 0, 0, 0, 0, 0); endtask
    task automatic do_pop();  step(0, 0, 1, 0, 0, 0, 0); endtask
    task automatic do_read(); step(0, 0, 0, 1, 0, 0, 0); endtask
    task automatic ser_send(input logic [7:0] d);
        for (int i = 0; i < 8; i++) step(0, 0, 0, 0, 0, 1, d[i]);
    endtask

    // monitor: compares delivered bytes with the scoreboard
    always @(negedge clk) begin
        if (rst_n && pop_valid) begin
            if (sb.size() == 0) chk("R11 unexpected pop_valid", 1, 0);
            else chk("R1 order", pop_data, sb.pop_front());
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; errs++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_outs("R8 reset");

        wr_byte(8'h10);
        chk_outs("R3 first write");
        do_read();
        chk_outs("R8 read clears");
        for (int i = 1; i < 8; i++) wr_byte(8'h10 + 8'(i));
        do_read();
        chk_outs("R8 read after 8");
        wr_byte(8'h18);
        chk_outs("R4 ninth write");
        for (int i = 9; i < 16; i++) wr_byte(8'h10 + 8'(i));
        chk_outs("R2 full");
        wr_byte(8'hEE);
        chk_outs("R5 overflow");

        do_pop();
        chk("R11 pop_valid", pop_valid, 1);
        chk_outs("R2 ready back");
        for (int i = 0; i < 6; i++) do_pop();
        chk_outs("R3 above half");
        do_pop();
        chk_outs("R3 half crossing");
        step(0, 0, 1, 1, 0, 0, 0);
        chk_outs("R8 set wins");
        do_read();
        chk_outs("R8 cleared");

        for (int i = 0; i < 7; i++) do_pop();
        do_read();
        do_pop();
        chk("R6 pop_valid", pop_valid, 0);
        chk("R6 pop_data", pop_data, 0);
        chk_outs("R6 underrun");
        do_read();

        step(0, 0, 0, 0, 1, 0, 0);
        chk_outs("R7 phrase end");
        do_read();
        chk_outs("R8 after phrase");

        ser_mode = 1'b1;
        for (int i = 0; i < 7; i++) step(0, 0, 0, 0, 0, 1, i[0]);
        chk_outs("R9 partial byte");
        step(0, 0, 0, 0, 0, 1, 1'b1);
        chk_outs("R9 eighth bit");
        do_read();
        wr_byte(8'hFF);
        chk_outs("R10 host write ignored");
        ser_send(8'hA5);
        ser_send(8'h3C);
        ser_mode = 1'b0;
        for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 0, 1, 1'b1);
        do_read();
        chk_outs("R10 serial ignored");
        for (int i = 0; i < 3; i++) do_pop();
        do_pop();
        chk("R10 nothing extra stored", pop_valid, 0);
        chk_outs("R10 drained");
        @(negedge clk);
        chk("R11 all delivered", sb.size(), 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule